// File: doc/BRIEF.md
# Seconds Counter with Alarm and Periodic Tick

This block keeps wall-clock time as a 32-bit count of seconds. A slow reference (nominally 32768 Hz) arrives as a one-cycle enable pulse, `ref_tick`, synchronous to the system clock. A programmable prescaler turns these pulses into a once-per-second tick. A trim value shortens one second in every trim period by a few reference cycles, which corrects a fast or slow crystal.

Each tick advances the seconds count. When the new count equals the programmed alarm value, an alarm event is raised. Both the tick and the alarm are recorded as sticky event flags in a status word. That word also holds one interrupt enable for each event. Each event has its own interrupt line, and the line is driven while the flag and its enable are both set.

Software reaches four 32-bit words through a word-indexed register bus. A write takes effect on the clock edge. Read data is combinational from the current state.

Top module: `rtc_sec_top`

## Requirements
- R1: After reset, every register reads 0 and both interrupt outputs are low.
- R2: Word index 0 is the seconds count, 1 is the alarm value, 2 is status and 3 is prescale/trim. In word 3, bits 15:0 hold the divide value and bits 25:16 hold the trim value. All other bits of words 2 and 3 read 0.
- R3: With divide value D, the seconds count advances once every D+1 reference pulses, so D=0 gives one advance per pulse. Writing the seconds word or word 3 restarts the sub-second phase and the trim period.
- R4: Status bit 1 (tick flag) sets on every second boundary, whatever its enable is.
- R5: Status bit 0 (alarm flag) sets when the count, just after it advances, equals the alarm word. A software write that makes the count equal to the alarm does not set it.
- R6: Writing 1 to status bit 0 or bit 1 clears that flag. Writing 0 to either leaves it unchanged.
- R7: Status bits 2 (alarm enable) and 3 (tick enable) are plain read/write bits. Writing 0 to status disables both interrupts.
- R8: `irq_tick` is high exactly while bits 1 and 3 are both set. `irq_alarm` is high exactly while bits 0 and 2 are both set.
- R9: In each period of TRIM_PERIOD seconds (default 1024), the last second lasts D+1-T reference pulses instead of D+1, with that length held at no fewer than 1.
- R10: A seconds write takes priority over a tick in the same cycle. The count wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per reference oscillator period |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| irq_tick | output | 1 | Once-per-second interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
On every cycle, the assertions check how the prescaler steps and restarts, how the count advances or holds, and that events set their flags while write-one-to-clear removes them. Only the bench scenarios can show the end-to-end period. They sweep the divide value against many pulse counts, run a full trim period to find the one shortened second, and exercise the alarm match, the write-versus-tick race, counter wrap and readback of every field.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
    localparam int DATA_W = 32;
    localparam int DIV_W  = 16;
    localparam int TRIM_W = 10;
    localparam int TRIM_LSB = 16;

    localparam logic [1:0] IDX_SECS  = 2'd0;
    localparam logic [1:0] IDX_ALARM = 2'd1;
    localparam logic [1:0] IDX_STAT  = 2'd2;
    localparam logic [1:0] IDX_PRESC = 2'd3;

    typedef struct packed {
        logic tick_en;   // bit 3
        logic alarm_en;  // bit 2
        logic tick_fl;   // bit 1
        logic alarm_fl;  // bit 0
    } stat_t;

    typedef struct packed {
        logic [TRIM_W-1:0] trim;
        logic [DIV_W-1:0]  div;
    } presc_t;

    function automatic logic [DIV_W-1:0] second_limit(
        input logic [DIV_W-1:0] div, input logic [TRIM_W-1:0] trim, input logic apply);
        logic [DIV_W-1:0] t;
        t = apply ? DIV_W'(trim) : '0;
        return (div > t) ? div - t : '0;
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_sec_pkg::*;
#(
    parameter int TRIM_PERIOD = 1024
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   ref_tick,
    input  logic   restart,
    input  presc_t cfg,
    output logic   tick
);
    localparam int TP_W = (TRIM_PERIOD > 1) ? $clog2(TRIM_PERIOD) : 1;

    logic [DIV_W-1:0] phase;
    logic [TP_W-1:0]  sec_idx;
    logic [DIV_W-1:0] limit;
    logic             last_sec;

    assign last_sec = (sec_idx == TP_W'(TRIM_PERIOD - 1));
    assign limit    = second_limit(cfg.div, cfg.trim, last_sec);
    assign tick     = ref_tick && !restart && (phase >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase   <= '0;
            sec_idx <= '0;
        end else if (tick) begin
            phase   <= '0;
            sec_idx <= last_sec ? '0 : sec_idx + 1'b1;
        end else if (ref_tick) begin
            phase   <= phase + 1'b1;
        end
    end

    a_r3_phase_steps: assert property (@(posedge clk) disable iff (rst)
        (ref_tick && !tick && !restart) |=> phase == $past(phase) + 1'b1);
    a_r3_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> (phase == '0 && sec_idx == '0));
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_sec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_secs,
    input  logic              wr_alarm,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] secs,
    output logic [DATA_W-1:0] alarm,
    output logic              alarm_hit
);
    logic [DATA_W-1:0] secs_next;

    assign secs_next = secs + 1'b1;
    assign alarm_hit = tick && !wr_secs && (secs_next == alarm);

    always_ff @(posedge clk) begin
        if (rst) begin
            secs  <= '0;
            alarm <= '0;
        end else begin
            if (wr_secs)   secs  <= wdata;
            else if (tick) secs  <= secs_next;
            if (wr_alarm)  alarm <= wdata;
        end
    end

    a_r10_advance: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_secs) |=> secs == $past(secs) + 1'b1);
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_secs) |=> $stable(secs));
    a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_secs |=> secs == $past(wdata));
endmodule

// File: rtl/rtc_status.sv
module rtc_status
    import rtc_sec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  alarm_hit,
    input  logic  wr_stat,
    input  stat_t wstat,
    output stat_t stat,
    output logic  irq_tick,
    output logic  irq_alarm
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            if (wr_stat) begin
                stat.tick_en  <= wstat.tick_en;
                stat.alarm_en <= wstat.alarm_en;
            end
            if (tick)                          stat.tick_fl  <= 1'b1;
            else if (wr_stat && wstat.tick_fl) stat.tick_fl  <= 1'b0;
            if (alarm_hit)                      stat.alarm_fl <= 1'b1;
            else if (wr_stat && wstat.alarm_fl) stat.alarm_fl <= 1'b0;
        end
    end

    assign irq_tick  = stat.tick_fl && stat.tick_en;
    assign irq_alarm = stat.alarm_fl && stat.alarm_en;

    a_r4_tick_sets: assert property (@(posedge clk) disable iff (rst)
        tick |=> stat.tick_fl);
    a_r5_alarm_sets: assert property (@(posedge clk) disable iff (rst)
        alarm_hit |=> stat.alarm_fl);
    a_r6_w1c_alarm: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && wstat.alarm_fl && !alarm_hit) |=> !stat.alarm_fl);
    a_r6_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !wstat.tick_fl && $past(stat.tick_fl)) |=> stat.tick_fl);
    a_r7_enables_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_stat |=> ($stable(stat.tick_en) && $stable(stat.alarm_en)));
endmodule

// File: rtl/rtc_sec_top.sv
module rtc_sec_top
    import rtc_sec_pkg::*;
#(
    parameter int TRIM_PERIOD = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_tick,
    output logic              irq_alarm
);
    localparam int PRESC_W = DIV_W + TRIM_W;

    logic              wr_secs, wr_alarm, wr_stat, wr_presc;
    logic              tick, alarm_hit;
    logic [DATA_W-1:0] secs, alarm;
    presc_t            presc;
    stat_t             stat;
    logic              unused_wbits;

    assign wr_secs  = bus_wr && (bus_addr == IDX_SECS);
    assign wr_alarm = bus_wr && (bus_addr == IDX_ALARM);
    assign wr_stat  = bus_wr && (bus_addr == IDX_STAT);
    assign wr_presc = bus_wr && (bus_addr == IDX_PRESC);
    assign unused_wbits = ^bus_wdata[DATA_W-1:PRESC_W];

    always_ff @(posedge clk) begin
        if (rst)           presc <= '0;
        else if (wr_presc) presc <= bus_wdata[PRESC_W-1:0];
    end

    rtc_prescaler #(.TRIM_PERIOD(TRIM_PERIOD)) u_presc (
        .clk(clk), .rst(rst), .ref_tick(ref_tick),
        .restart(wr_secs || wr_presc), .cfg(presc), .tick(tick));

    rtc_counter u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .wr_secs(wr_secs),
        .wr_alarm(wr_alarm), .wdata(bus_wdata), .secs(secs),
        .alarm(alarm), .alarm_hit(alarm_hit));

    rtc_status u_stat (
        .clk(clk), .rst(rst), .tick(tick), .alarm_hit(alarm_hit),
        .wr_stat(wr_stat), .wstat(bus_wdata[3:0]), .stat(stat),
        .irq_tick(irq_tick), .irq_alarm(irq_alarm));

    always_comb begin
        unique case (bus_addr)
            IDX_SECS:  bus_rdata = secs;
            IDX_ALARM: bus_rdata = alarm;
            IDX_STAT:  bus_rdata = DATA_W'(stat);
            default:   bus_rdata = DATA_W'(presc);
        endcase
    end

    a_r8_no_irq_without_enable: assert property (@(posedge clk) disable iff (rst)
        (!stat.alarm_en |-> !irq_alarm) and (!stat.tick_en |-> !irq_tick));
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (secs == '0 && stat == '0 && !irq_tick && !irq_alarm));
endmodule

// File: tb/sim_rtc_sec_top.sv
module sim_rtc_sec_top;
    logic        clk = 0, rst = 1, ref_tick = 0, bus_wr = 0;
    logic [1:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        irq_tick, irq_alarm;
    int n_run = 0, n_fail = 0;

    rtc_sec_top u0 (.clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_tick(irq_tick), .irq_alarm(irq_alarm));

    always #2 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic pulses(int n);
        if (n > 0) begin
            @(negedge clk); ref_tick = 1;
            repeat (n) @(negedge clk);
            ref_tick = 0;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin rd(2'(a), v); check("R1 reset reg", v, 0); end
        check("R1 irqs", {30'b0, irq_tick, irq_alarm}, 0);
        // R2 field layout
        wr(3, 32'hFFFF_FFFF); rd(3, v); check("R2 presc mask", v, 32'h03FF_FFFF);
        wr(1, 32'hA5A5_1234); rd(1, v); check("R2 alarm rw", v, 32'hA5A5_1234);
        wr(2, 32'hFFFF_FFFC); rd(2, v); check("R2 stat mask", v, 32'hC);
        wr(2, 0);             rd(2, v); check("R7 zero disables", v, 0);
        wr(1, 0);
        // R3 sweep of divide value against pulse counts
        for (int d = 0; d < 6; d++) begin
            wr(3, d);
            for (int n = 1; n <= 14; n++) begin
                wr(0, 0); pulses(n); rd(0, v);
                check("R3 period", v, n / (d + 1));
            end
        end
        // R4 tick flag independent of enable, R8 gating
        wr(3, 0); wr(2, 32'h3); rd(2, v); check("R6 cleared", v, 0);
        wr(1, 32'hFFFF); wr(0, 0); pulses(1); rd(2, v);
        check("R4 tick flag no enable", v, 32'h2);
        check("R8 irq_tick low w/o enable", irq_tick, 0);
        wr(2, 32'h8); check("R8 irq_tick high", irq_tick, 1);
        wr(2, 32'h0); rd(2, v); check("R6 zero keeps flag", v, 32'h2);
        check("R7 irq_tick off", irq_tick, 0);
        wr(2, 32'h2); rd(2, v); check("R6 w1c tick", v, 0);
        // R5 alarm
        wr(1, 5); wr(0, 3); pulses(1); rd(2, v); check("R5 no early alarm", v & 1, 0);
        pulses(1); rd(2, v); check("R5 alarm flag", v & 1, 1);
        check("R8 irq_alarm low w/o enable", irq_alarm, 0);
        wr(2, 32'h4); check("R8 irq_alarm high", irq_alarm, 1);
        wr(2, 32'h5); rd(2, v); check("R6 w1c alarm", v & 1, 0);
        check("R8 irq_alarm cleared", irq_alarm, 0);
        wr(0, 5); rd(2, v); check("R5 write match no flag", v & 1, 0);
        wr(2, 32'h3);
        // R10 wrap and write priority
        wr(1, 32'h1234); wr(0, 32'hFFFF_FFFF); pulses(1); rd(0, v);
        check("R10 wrap", v, 0);
        @(negedge clk); ref_tick = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 100;
        @(negedge clk); ref_tick = 0; bus_wr = 0;
        rd(0, v); check("R10 write beats tick", v, 100);
        // R9 trim: D=3, T=2 -> 1023 seconds of 4 pulses then one of 2
        wr(3, (2 << 16) | 3); wr(0, 0);
        pulses(4093); rd(0, v); check("R9 before short second", v, 1023);
        pulses(1);    rd(0, v); check("R9 short second", v, 1024);
        pulses(3);    rd(0, v); check("R9 normal after", v, 1024);
        pulses(1);    rd(0, v); check("R9 normal after end", v, 1025);
        // R9 trim larger than divide clamps to one pulse
        wr(3, (9 << 16) | 1); wr(0, 0);
        pulses(2046); rd(0, v); check("R9 clamp before", v, 1023);
        pulses(1);    rd(0, v); check("R9 clamp short", v, 1024);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule